// File: doc/BRIEF.md
# Scanline interrupt counter

This block raises an interrupt request after a programmed number of visible scanlines. Software writes a reload value to a holding latch, moves it into an 8-bit down-counter, and arms or disarms the request through a small set of write addresses decoded from the CPU bus. A once-per-line tick, together with the current line number and a rendering-active flag, decrements the counter. When the counter steps from one to zero while the interrupt is armed, the request goes high. It stays high until software disarms it.

Three loading paths lead to the counter. A write to the reload address copies the latch. An arming write copies the latch if a latch value is pending. A latch write made after a disarm, with no tick in between, also loads the counter at once. The counter never reloads itself: once it reaches zero it stays there until software loads it again.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write to the latch address (upper three address bits 110, bit 0 low) stores the data in the latch and marks it pending. When no disarm has happened since the last tick, the counter is left unchanged.
- R2: A latch write made after a disarm write, with no line tick in between, loads the data straight into the counter and clears the pending mark.
- R3: A write to the reload address (upper bits 110, bit 0 high) copies the latch into the counter.
- R4: A write to the disarm address (upper bits 111, bit 0 low) clears the arm bit, drops the request on the next cycle and sets the post-disarm flag. While disarmed, the counter reaching zero raises no request.
- R5: A write to the arm address (upper bits 111, bit 0 high) sets the arm bit. If a latch value is pending, the same write also copies the latch into the counter. The pending mark stays set.
- R6: Every line tick clears the post-disarm flag, whatever the line number or rendering flag.
- R7: The counter is decremented only on a tick whose line number is at most LAST_LINE while rendering is active.
- R8: A counted tick decrements a non-zero counter. The step from one to zero raises the request if armed. A zero counter stays at zero on ticks.
- R9: Once raised, the request stays high through ticks and through writes other than a disarm.
- R10: Writes to addresses outside the four decoded ones, and bus cycles with write enable low, have no effect.
- R11: A counter load in the same cycle as a counted tick takes priority, and that tick does not decrement.
- R12: After reset the request is low, the counter is zero, and the arm bit, pending mark and post-disarm flag are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | CPU write address |
| wr_data_i | input | CNT_W | CPU write data |
| line_tick_i | input | 1 | One-cycle pulse per scanline |
| line_num_i | input | LINE_W | Current scanline number |
| render_en_i | input | 1 | Rendering active |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with a 4-bit counter, a 5-bit line number and LAST_LINE set to 19. These settings make every reload value from 0 to 15 reachable in a few ticks, so the tick count to the request can be checked against each value. Every line number from 0 to 31 is swept for the counting window, which covers both sides of the last-line boundary. Directed sequences then tell the loading paths apart: one for the pending mark, one for the post-disarm flag and one for a load in the same cycle as a tick. Each sequence is built so that a wrong path gives a different tick count.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LATCH,
    CMD_RELOAD,
    CMD_DISARM,
    CMD_ARM
  } irq_cmd_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output irq_cmd_e          cmd_o
);
  logic [2:0] region;
  logic       unused_addr;

  assign region      = addr_i[ADDR_W-1:ADDR_W-3];
  assign unused_addr = ^addr_i[ADDR_W-4:1];

  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_en_i) begin
      unique case ({region, addr_i[0]})
        4'b1100: cmd_o = CMD_LATCH;
        4'b1101: cmd_o = CMD_RELOAD;
        4'b1110: cmd_o = CMD_DISARM;
        4'b1111: cmd_o = CMD_ARM;
        default: cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  irq_cmd_e         cmd_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] latch_o,
  output logic             arm_o,
  output logic             ack_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  logic [CNT_W-1:0] latch_q;
  logic             pend_q, post_dis_q, arm_q;
  logic             direct_ld;

  assign direct_ld = (cmd_i == CMD_LATCH) && post_dis_q;
  assign load_o    = (cmd_i == CMD_RELOAD) || direct_ld ||
                     ((cmd_i == CMD_ARM) && pend_q);
  // direct path bypasses the latch register
  assign load_val_o = direct_ld ? data_i : latch_q;
  assign ack_o      = (cmd_i == CMD_DISARM);
  assign latch_o    = latch_q;
  assign arm_o      = arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q    <= '0;
      pend_q     <= 1'b0;
      post_dis_q <= 1'b0;
      arm_q      <= 1'b0;
    end else begin
      if (cmd_i == CMD_LATCH) begin
        latch_q <= data_i;
        pend_q  <= !post_dis_q;
      end
      if (cmd_i == CMD_DISARM) arm_q <= 1'b0;
      else if (cmd_i == CMD_ARM) arm_q <= 1'b1;
      if (cmd_i == CMD_DISARM) post_dis_q <= 1'b1;
      else if (tick_i) post_dis_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_down_counter.sv
module irq_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             count_i,
  input  logic             arm_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, hit;

  assign hit   = !load_i && count_i && (cnt_q == CNT_W'(1));
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (load_i) cnt_q <= load_val_i;
      else if (count_i && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
      if (ack_i) irq_q <= 1'b0;
      else if (hit && arm_i) irq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              line_tick_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              irq_o
);
  localparam logic [LINE_W-1:0] LastL = LINE_W'(LAST_LINE);

  irq_cmd_e         cmd;
  logic [CNT_W-1:0] latch, load_val, cnt;
  logic             arm, ack, load, count_en;

  assign count_en = line_tick_i && render_en_i && (line_num_i <= LastL);

  irq_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i(wr_en_i),
    .addr_i (wr_addr_i),
    .cmd_o  (cmd)
  );

  irq_ctrl_regs #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .data_i    (wr_data_i),
    .tick_i    (line_tick_i),
    .latch_o   (latch),
    .arm_o     (arm),
    .ack_o     (ack),
    .load_o    (load),
    .load_val_o(load_val)
  );

  irq_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .count_i   (count_en),
    .arm_i     (arm),
    .ack_i     (ack),
    .cnt_o     (cnt),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/scanline_irq_checker.sv
module scanline_irq_checker #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              line_tick_i,
  input logic [LINE_W-1:0] line_num_i,
  input logic              render_en_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  latch_i
);
  localparam logic [LINE_W-1:0] LastL = LINE_W'(LAST_LINE);

  logic dis_wr, rel_wr, qual_tick, unused_mid;

  assign dis_wr     = wr_en_i && (wr_addr_i[ADDR_W-1:ADDR_W-3] == 3'b111) && !wr_addr_i[0];
  assign rel_wr     = wr_en_i && (wr_addr_i[ADDR_W-1:ADDR_W-3] == 3'b110) && wr_addr_i[0];
  assign qual_tick  = line_tick_i && render_en_i && (line_num_i <= LastL);
  assign unused_mid = ^wr_addr_i[ADDR_W-4:1];

  assert_reload_copies_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_wr |=> (cnt_i == $past(latch_i)));

  assert_disarm_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr |=> !irq_o);

  assert_rise_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(qual_tick));

  assert_zero_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i == '0) && !wr_en_i) |=> (cnt_i == '0));

  assert_no_climb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (cnt_i <= $past(cnt_i)));

  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !dis_wr) |=> irq_o);
endmodule

bind scanline_irq_counter scanline_irq_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .line_tick_i(line_tick_i),
  .line_num_i (line_num_i),
  .render_en_i(render_en_i),
  .irq_o      (irq_o),
  .cnt_i      (cnt),
  .latch_i    (latch)
);

// File: tb/scanline_irq_counter_bench.sv
module scanline_irq_counter_bench;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 4;
  localparam int LINE_W = 5;
  localparam int LAST   = 19;

  localparam logic [15:0] A_LATCH  = 16'hC000;
  localparam logic [15:0] A_RELOAD = 16'hC001;
  localparam logic [15:0] A_DIS    = 16'hE000;
  localparam logic [15:0] A_ARM    = 16'hE001;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic              tick = 1'b0;
  logic [LINE_W-1:0] line = '0;
  logic              render = 1'b0;
  logic              irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  scanline_irq_counter #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W), .LAST_LINE(LAST)
  ) u_scanline_irq_counter (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .line_tick_i(tick), .line_num_i(line),
    .render_en_i(render), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input int ln, input bit rend);
    @(negedge clk);
    tick = 1'b1; line = LINE_W'(ln); render = rend;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // counted ticks until request; 0 if none in 20; held reports stickiness
  task automatic run(output int first, output bit held);
    first = 0; held = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      tk(0, 1'b1);
      if (irq && first == 0) first = i;
      else if (!irq && first != 0) held = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int k;
    bit h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(irq == 1'b0, "R12 irq after reset", int'(irq), 0);
    wr(A_ARM, 0);
    run(k, h);
    check(k == 0, "R12 no pending, zero counter", k, 0);

    // R3 R8 R9: every reload value
    for (int n = 0; n < 16; n++) begin
      wr(A_DIS, 0);
      tk(31, 1'b1);
      wr(A_LATCH, n);
      wr(A_RELOAD, 0);
      wr(A_ARM, 0);
      run(k, h);
      check(k == n, "R3 R8 ticks to request", k, n);
      if (n > 0) check(h, "R9 request held over ticks", int'(h), 1);
    end

    // R10 R9: ignored writes keep the request
    wr(16'h8000, 15); check(irq, "R10 write 8000", int'(irq), 1);
    wr(16'h8001, 15); check(irq, "R10 write 8001", int'(irq), 1);
    wr(16'hA000, 15); check(irq, "R10 write A000", int'(irq), 1);
    wr(16'hA001, 15); check(irq, "R10 write A001", int'(irq), 1);
    @(negedge clk); wr_addr = A_DIS; wr_en = 1'b0;
    @(negedge clk);
    check(irq, "R10 strobe low", int'(irq), 1);
    wr(A_LATCH, 2); check(irq, "R9 latch write keeps request", int'(irq), 1);
    wr(A_DIS, 0);   check(!irq, "R4 disarm drops request", int'(irq), 0);

    // R7: counting window over every line
    for (int ln = 0; ln < 32; ln++) begin
      wr(A_DIS, 0);
      tk(31, 1'b1);
      wr(A_LATCH, 1);
      wr(A_RELOAD, 0);
      wr(A_ARM, 0);
      tk(ln, 1'b1);
      check(irq == (ln <= LAST), $sformatf("R7 line %0d", ln), int'(irq), int'(ln <= LAST));
    end
    wr(A_DIS, 0);
    tk(31, 1'b1);
    wr(A_LATCH, 1);
    wr(A_ARM, 0);
    tk(5, 1'b0);
    check(!irq, "R7 rendering off", int'(irq), 0);
    tk(5, 1'b1);
    check(irq, "R7 counter kept while rendering off", int'(irq), 1);

    // R2: direct load clears pending
    wr(A_DIS, 0);
    wr(A_LATCH, 3);
    tk(0, 1'b1);
    wr(A_ARM, 0);
    run(k, h);
    check(k == 2, "R2 direct load, pending cleared", k, 2);

    // R1: latch write leaves the counter
    wr(A_DIS, 0);
    tk(31, 1'b1);
    wr(A_LATCH, 3);
    wr(A_RELOAD, 0);
    wr(A_ARM, 0);
    wr(A_LATCH, 9);
    run(k, h);
    check(k == 3, "R1 latch write no load", k, 3);
    // R5: arm with pending loads latch
    wr(A_DIS, 0);
    tk(31, 1'b1);
    wr(A_ARM, 0);
    run(k, h);
    check(k == 9, "R5 arm loads pending latch", k, 9);
    wr(A_DIS, 0);
    wr(A_ARM, 0);
    run(k, h);
    check(k == 9, "R5 pending stays set", k, 9);

    // R6: tick clears post-disarm flag
    wr(A_DIS, 0);
    tk(31, 1'b0);
    wr(A_LATCH, 4);
    tk(0, 1'b1);
    wr(A_ARM, 0);
    run(k, h);
    check(k == 4, "R6 flag cleared by tick", k, 4);

    // R11: load wins over same-cycle tick
    wr(A_DIS, 0);
    tk(31, 1'b1);
    wr(A_LATCH, 6);
    wr(A_ARM, 0);
    tk(0, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_RELOAD; tick = 1'b1; line = '0; render = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    run(k, h);
    check(k == 6, "R11 load priority", k, 6);

    // R4 R8: disarmed counter reaches zero silently
    wr(A_DIS, 0);
    tk(31, 1'b1);
    wr(A_LATCH, 2);
    wr(A_ARM, 0);
    wr(A_DIS, 0);
    for (int i = 0; i < 4; i++) begin
      tk(0, 1'b1);
      check(!irq, "R4 no request while disarmed", int'(irq), 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule